// File: doc/BRIEF.md
# BF16 Pair Dot-Product Accumulator

This block produces one FP32 element of a tile multiply-accumulate. It takes a stream of beats. Each beat carries one 32-bit word from a row of the A operand and one 32-bit word from a column of the B operand. Each word packs two BF16 numbers. On every accepted beat the block multiplies the two low halves and the two high halves. It adds the low-half product and then the high-half product into an FP32 running sum.

A beat marked as the opening beat also supplies the starting C value, which replaces whatever the running sum held. A beat marked as the closing beat causes the finished sum to appear on the output with a single-cycle valid strobe. Rounding is fixed to nearest-even. Subnormal inputs and subnormal results are treated as zero. No exception status is produced, and no outside rounding control is read.

Top module: `bf16_pair_dot_acc`

## Requirements
- R1: While reset is held, `inReady` and `outValid` are 0 and `outData` is 0. From the first clock edge after reset is released, `inReady` is 1.
- R2: On an accepted beat, bits [15:0] of `inA` are multiplied by bits [15:0] of `inB`, and bits [31:16] by bits [31:16]. Each BF16 value is sign in bit 15, biased exponent in bits 14:7 and fraction in bits 6:0. Each product is formed exactly as an FP32 value. A product of magnitude 2^128 or more becomes an infinity of the product's sign.
- R3: On each beat, the running sum first has the low-half product added and rounded to FP32 with round-to-nearest-even. Then the high-half product is added and rounded the same way.
- R4: A beat with `inFirst` high starts from `inInitC`, ignoring the previous sum. A beat with `inFirst` low continues from the previous sum, and `inInitC` has no effect.
- R5: One cycle after an accepted beat with `inLast` high, `outValid` is 1 for exactly one cycle and `outData` shows the final sum. `outData` keeps that value until the next such beat.
- R6: A cycle with `inValid` low leaves the running sum unchanged and raises no output strobe, whatever the other inputs carry.
- R7: Several values are treated as a zero with the same sign: a BF16 input with exponent field 0, an initial C with exponent field 0, and any product or rounded sum whose magnitude is below 2^-126. `outData` never holds a nonzero value with exponent field 0.
- R8: A NaN input, infinity times zero, or the sum of opposite infinities gives 0x7FC00000. Otherwise an infinite operand yields an infinity of its sign.
- R9: An exact cancellation of two nonzero values gives +0. The sum of two negative zeros gives -0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Beat present on the input |
| inReady | output | 1 | Block accepts a beat this cycle |
| inFirst | input | 1 | Beat opens a new dot product and carries the initial C |
| inLast | input | 1 | Beat closes the dot product |
| inInitC | input | 32 | Initial FP32 C value, used on an opening beat |
| inA | input | WORD_W (32) | Packed BF16 pair from A |
| inB | input | WORD_W (32) | Packed BF16 pair from B |
| outValid | output | 1 | One-cycle strobe marking a finished result |
| outData | output | 32 | Finished FP32 dot-product value |

## Verification
The bench builds the block with its default word width of 32, which gives two BF16 lanes per beat. At this width the low-then-high addition order decides the result, and the two-step rounding can be told apart from a single combined addition, both in the directed tie cases and in the random ones. Dots run from 1 to 12 beats. Idle cycles carrying junk control bits are placed between beats. These patterns exercise the restart on the opening beat, cases where the opening and closing flags fall on the same beat, and the guarantee that idle cycles do nothing. Exponents are drawn both from a narrow band, where cancellation and rounding dominate, and from the full range, where overflow, flush-to-zero and infinities appear.

// File: rtl/bfdot_pkg.sv
package bfdot_pkg;
  localparam int FP_W = 32;
  localparam int BF_W = 16;
  localparam logic [31:0] CANON_NAN = 32'h7FC0_0000;

  typedef struct packed {
    logic loadInit;
    logic step;
    logic emit;
  } ctrl_strobes_t;

  function automatic logic [31:0] flushDenorm(input logic [31:0] v);
    if (v[30:23] == 8'd0) return {v[31], 31'd0};
    return v;
  endfunction

  function automatic logic [4:0] lzc27(input logic [26:0] v);
    logic [4:0] n;
    logic found;
    n = 5'd0;
    found = 1'b0;
    for (int i = 26; i >= 0; i--) begin
      if (!found) begin
        if (v[i]) found = 1'b1;
        else n = n + 5'd1;
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/bfdot_mul.sv
module bfdot_mul import bfdot_pkg::*; (
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  output logic [31:0] prod
);
  logic sP;
  logic [7:0] eA, eB;
  logic [6:0] mA, mB;
  logic zA, zB, iA, iB, nA, nB;
  logic [15:0] mulRaw;
  logic signed [10:0] eSum;
  logic [22:0] frac;

  assign sP = opA[15] ^ opB[15];
  assign eA = opA[14:7];
  assign eB = opB[14:7];
  assign mA = opA[6:0];
  assign mB = opB[6:0];
  assign zA = (eA == 8'd0);
  assign zB = (eB == 8'd0);
  assign iA = (eA == 8'hFF) && (mA == 7'd0);
  assign iB = (eB == 8'hFF) && (mB == 7'd0);
  assign nA = (eA == 8'hFF) && (mA != 7'd0);
  assign nB = (eB == 8'hFF) && (mB != 7'd0);

  always_comb begin
    mulRaw = {8'd0, 1'b1, mA} * {8'd0, 1'b1, mB};
    eSum = $signed({3'b0, eA}) + $signed({3'b0, eB}) - 11'sd127
         + $signed({10'd0, mulRaw[15]});
    frac = mulRaw[15] ? {mulRaw[14:0], 8'd0} : {mulRaw[13:0], 9'd0};
    if (nA || nB || (iA && zB) || (iB && zA)) prod = CANON_NAN;
    else if (iA || iB) prod = {sP, 8'hFF, 23'd0};
    else if (zA || zB) prod = {sP, 31'd0};
    else if (eSum >= 11'sd255) prod = {sP, 8'hFF, 23'd0};
    else if (eSum <= 11'sd0) prod = {sP, 31'd0};
    else prod = {sP, eSum[7:0], frac};
  end

  always_comb begin
    assert_prod_ftz_R7: assert (prod[30:23] != 8'd0 || prod[22:0] == 23'd0);
  end
endmodule

// File: rtl/bfdot_add.sv
module bfdot_add import bfdot_pkg::*; (
  input  logic [31:0] opX,
  input  logic [31:0] opY,
  output logic [31:0] sum
);
  logic sX, sY, zX, zY, infX, infY, nanX, nanY;
  logic [7:0] eX, eY;
  logic [22:0] fX, fY;
  logic xBig, sBig;
  logic [7:0] eBig, eSm, dExp;
  logic [23:0] mBig, mSm;
  logic [4:0] shAmt, lz;
  logic [49:0] wide;
  logic [26:0] bgExt, smExt, norm, diff;
  logic [27:0] sum28;
  logic signed [10:0] expW, expF;
  logic rUp;
  logic [33:0] packW;

  assign sX = opX[31];
  assign sY = opY[31];
  assign eX = opX[30:23];
  assign eY = opY[30:23];
  assign fX = opX[22:0];
  assign fY = opY[22:0];
  assign zX = (eX == 8'd0);
  assign zY = (eY == 8'd0);
  assign infX = (eX == 8'hFF) && (fX == 23'd0);
  assign infY = (eY == 8'hFF) && (fY == 23'd0);
  assign nanX = (eX == 8'hFF) && (fX != 23'd0);
  assign nanY = (eY == 8'hFF) && (fY != 23'd0);

  always_comb begin
    xBig  = {eX, fX} >= {eY, fY};
    sBig  = xBig ? sX : sY;
    eBig  = xBig ? eX : eY;
    eSm   = xBig ? eY : eX;
    mBig  = {1'b1, xBig ? fX : fY};
    mSm   = {1'b1, xBig ? fY : fX};
    dExp  = eBig - eSm;
    shAmt = (dExp > 8'd31) ? 5'd31 : dExp[4:0];
    wide  = {mSm, 26'd0} >> shAmt;
    smExt = {wide[49:24], |wide[23:0]};
    bgExt = {mBig, 3'd0};
    sum28 = '0;
    diff  = '0;
    lz    = '0;
    if (sX == sY) begin
      sum28 = {1'b0, bgExt} + {1'b0, smExt};
      if (sum28[27]) begin
        norm = {sum28[27:2], sum28[1] | sum28[0]};
        expW = $signed({3'b0, eBig}) + 11'sd1;
      end else begin
        norm = sum28[26:0];
        expW = $signed({3'b0, eBig});
      end
    end else begin
      diff = bgExt - smExt;
      lz   = lzc27(diff);
      norm = diff << lz;
      expW = $signed({3'b0, eBig}) - $signed({6'd0, lz});
    end
    rUp   = norm[2] & (norm[1] | norm[0] | norm[3]);
    packW = {expW, norm[25:3]} + {33'd0, rUp};
    expF  = $signed(packW[33:23]);

    if (nanX || nanY || (infX && infY && (sX ^ sY))) sum = CANON_NAN;
    else if (infX) sum = {sX, 8'hFF, 23'd0};
    else if (infY) sum = {sY, 8'hFF, 23'd0};
    else if (zX && zY) sum = {sX & sY, 31'd0};
    else if (zX) sum = opY;
    else if (zY) sum = opX;
    else if (!norm[26]) sum = 32'd0;
    else if (expF >= 11'sd255) sum = {sBig, 8'hFF, 23'd0};
    else if (expF <= 11'sd0) sum = {sBig, 31'd0};
    else sum = {sBig, expF[7:0], packW[22:0]};
  end

  always_comb begin
    assert_no_denorm_R7: assert (sum[30:23] != 8'd0 || sum[22:0] == 23'd0);
  end
endmodule

// File: rtl/bfdot_datapath.sv
module bfdot_datapath import bfdot_pkg::*; #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobes_t       strobes,
  input  logic [FP_W-1:0]     initC,
  input  logic [WORD_W-1:0]   wordA,
  input  logic [WORD_W-1:0]   wordB,
  output logic [FP_W-1:0]     result
);
  localparam int LANES = WORD_W / BF_W;

  logic [LANES:0][FP_W-1:0]   chain;
  logic [LANES-1:0][FP_W-1:0] prods;
  logic [FP_W-1:0]            accQ;

  assign chain[0] = strobes.loadInit ? flushDenorm(initC) : accQ;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    bfdot_mul uMul (
      .opA (wordA[BF_W*g +: BF_W]),
      .opB (wordB[BF_W*g +: BF_W]),
      .prod(prods[g])
    );
    bfdot_add uAdd (
      .opX(chain[g]),
      .opY(prods[g]),
      .sum(chain[g+1])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ   <= '0;
      result <= '0;
    end else begin
      if (strobes.step) accQ <= chain[LANES];
      if (strobes.emit) result <= chain[LANES];
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.emit |=> $stable(result));

  assert_nan_canon_R8: assert property (@(posedge clk) disable iff (!rstN)
    (result[30:23] == 8'hFF && result[22:0] != 23'd0) |-> result == CANON_NAN);
endmodule

// File: rtl/bfdot_ctrl.sv
module bfdot_ctrl import bfdot_pkg::*; (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inFirst,
  input  logic          inLast,
  output logic          inReady,
  output ctrl_strobes_t strobes,
  output logic          outValid
);
  logic readyQ, accept;

  assign accept  = inValid & readyQ;
  assign inReady = readyQ;

  always_comb begin
    strobes.step     = accept;
    strobes.loadInit = accept & inFirst;
    strobes.emit     = accept & inLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      readyQ   <= 1'b1;
      outValid <= strobes.emit;
    end
  end

  assert_pulse_src_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid && inLast && inReady));

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/bf16_pair_dot_acc.sv
module bf16_pair_dot_acc import bfdot_pkg::*; #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inFirst,
  input  logic              inLast,
  input  logic [31:0]       inInitC,
  input  logic [WORD_W-1:0] inA,
  input  logic [WORD_W-1:0] inB,
  output logic              outValid,
  output logic [31:0]       outData
);
  ctrl_strobes_t strobes;

  bfdot_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inFirst (inFirst),
    .inLast  (inLast),
    .inReady (inReady),
    .strobes (strobes),
    .outValid(outValid)
  );

  bfdot_datapath #(.WORD_W(WORD_W)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .initC  (inInitC),
    .wordA  (inA),
    .wordB  (inB),
    .result (outData)
  );
endmodule

// File: tb/tb_bf16_pair_dot_acc.sv
`timescale 1ns/1ps
module tb_bf16_pair_dot_acc;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 16;
  localparam logic [31:0] QNAN = 32'h7FC0_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inFirst = 1'b0, inLast = 1'b0;
  logic [31:0] inInitC = '0;
  logic [WORD_W-1:0] inA = '0, inB = '0;
  logic inReady, outValid;
  logic [31:0] outData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [WORD_W-1:0] stimA [16];
  logic [WORD_W-1:0] stimB [16];

  always #2.5 clk = ~clk;

  bf16_pair_dot_acc #(.WORD_W(WORD_W)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inFirst(inFirst), .inLast(inLast), .inInitC(inInitC),
    .inA(inA), .inB(inB), .outValid(outValid), .outData(outData)
  );

  task automatic checkVal(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic real bfToReal(input logic [15:0] h);
    logic [10:0] e11;
    if (h[14:7] == 8'hFF)
      return (h[6:0] != 7'd0) ? $bitstoreal(64'h7FF8_0000_0000_0000)
                              : $bitstoreal({h[15], 11'h7FF, 52'd0});
    if (h[14:7] == 8'd0) return $bitstoreal({h[15], 63'd0});
    e11 = {3'b0, h[14:7]} + 11'd896;
    return $bitstoreal({h[15], e11, h[6:0], 45'd0});
  endfunction

  function automatic real fpToReal(input logic [31:0] f);
    logic [10:0] e11;
    if (f[30:23] == 8'hFF)
      return (f[22:0] != 23'd0) ? $bitstoreal(64'h7FF8_0000_0000_0000)
                                : $bitstoreal({f[31], 11'h7FF, 52'd0});
    if (f[30:23] == 8'd0) return $bitstoreal({f[31], 63'd0});
    e11 = {3'b0, f[30:23]} + 11'd896;
    return $bitstoreal({f[31], e11, f[22:0], 29'd0});
  endfunction

  function automatic logic [31:0] realToFp(input real r);
    logic [63:0] b;
    logic [23:0] keep;
    logic [24:0] k25;
    logic up;
    int ex;
    b = $realtobits(r);
    if (b[62:52] == 11'h7FF) return (b[51:0] != 52'd0) ? QNAN : {b[63], 8'hFF, 23'd0};
    if (b[62:52] == 11'd0) return {b[63], 31'd0};
    keep = {1'b1, b[51:29]};
    up = b[28] & ((|b[27:0]) | keep[0]);
    k25 = {1'b0, keep} + {24'd0, up};
    ex = int'(b[62:52]) - 896 + (k25[24] ? 1 : 0);
    if (ex >= 255) return {b[63], 8'hFF, 23'd0};
    if (ex <= 0) return {b[63], 31'd0};
    return {b[63], ex[7:0], k25[24] ? 23'd0 : k25[22:0]};
  endfunction

  function automatic logic [31:0] refStep(input logic [31:0] acc,
                                          input logic [WORD_W-1:0] a,
                                          input logic [WORD_W-1:0] b);
    logic [31:0] r, p;
    r = acc;
    for (int l = 0; l < LANES; l++) begin
      p = realToFp(bfToReal(a[16*l +: 16]) * bfToReal(b[16*l +: 16]));
      r = realToFp(fpToReal(r) + fpToReal(p));
    end
    return r;
  endfunction

  function automatic logic [15:0] randBf(input int wide);
    logic [7:0] e;
    if (wide != 0) e = 8'($urandom_range(255, 0));
    else e = 8'($urandom_range(134, 120));
    return {1'($urandom), e, 7'($urandom)};
  endfunction

  task automatic runDot(input int k, input logic [31:0] cInit, input int bubblePct,
                        input string tag, output logic [31:0] got);
    logic [31:0] acc;
    acc = realToFp(fpToReal(cInit));
    for (int i = 0; i < k; i++) begin
      if (i > 0 && $urandom_range(99, 0) < bubblePct) begin
        @(negedge clk);
        inValid = 1'b0; inFirst = 1'b1; inLast = 1'b1;
        inA = WORD_W'($urandom); inB = WORD_W'($urandom); inInitC = $urandom;
      end
      @(negedge clk);
      if (i > 0) checkVal({tag, " R6 no early strobe"}, {31'd0, outValid}, 32'd0);
      inValid = 1'b1;
      inFirst = (i == 0);
      inLast  = (i == k - 1);
      inA = stimA[i];
      inB = stimB[i];
      inInitC = (i == 0) ? cInit : $urandom;
      acc = refStep(acc, stimA[i], stimB[i]);
    end
    @(negedge clk);
    inValid = 1'b0; inFirst = 1'b0; inLast = 1'b0;
    checkVal({tag, " R5 strobe"}, {31'd0, outValid}, 32'd1);
    checkVal({tag, " value"}, outData, acc);
    got = outData;
    @(negedge clk);
    checkVal({tag, " R5 one-cycle pulse"}, {31'd0, outValid}, 32'd0);
    checkVal({tag, " R5 hold"}, outData, acc);
  endtask

  task automatic directed(input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c, input logic [31:0] expv, input string tag);
    logic [31:0] got;
    stimA[0] = a;
    stimB[0] = b;
    runDot(1, c, 0, tag, got);
    checkVal({tag, " constant"}, got, expv);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [31:0] got;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    checkVal("R1 ready in reset", {31'd0, inReady}, 32'd0);
    checkVal("R1 valid in reset", {31'd0, outValid}, 32'd0);
    checkVal("R1 data in reset", outData, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 ready after reset", {31'd0, inReady}, 32'd1);
    checkVal("R1 valid after reset", {31'd0, outValid}, 32'd0);

    directed(32'h4000_3FC0, 32'h4040_BF00, 32'h3F80_0000, 32'h40C8_0000, "R2 lane pairing");
    directed(32'h4000_0000, 32'h4000_0000, 32'h0000_0000, 32'h4080_0000, "R2 high lane");
    directed(32'h3980_3980, 32'h3980_3980, 32'h3F80_0000, 32'h3F80_0000, "R3 stepwise tie");
    directed(32'h0000_3980, 32'h0000_3980, 32'h3F80_0001, 32'h3F80_0002, "R3 tie to even");
    directed(32'h0000_0040, 32'h0000_3F80, 32'h3F80_0000, 32'h3F80_0000, "R7 denormal input");
    directed(32'h8000_8000, 32'h0000_0000, 32'h8000_0001, 32'h8000_0000, "R7 R9 negative zeros");
    directed(32'h0000_2000, 32'h0000_A000, 32'h00C0_0000, 32'h0000_0000, "R7 result flush");
    directed(32'h3F80_7FC1, 32'h3F80_3F80, 32'h3F80_0000, QNAN, "R8 nan input");
    directed(32'h0000_7F80, 32'h0000_0000, 32'h3F80_0000, QNAN, "R8 inf times zero");
    directed(32'hFF80_7F80, 32'h3F80_3F80, 32'h3F80_0000, QNAN, "R8 opposite infinities");
    directed(32'h0000_7180, 32'h0000_7180, 32'h3F80_0000, 32'h7F80_0000, "R2 R8 overflow to inf");
    directed(32'h0000_BF80, 32'h0000_4000, 32'h4000_0000, 32'h0000_0000, "R9 cancellation");

    for (int t = 0; t < 60; t++) begin
      int k;
      k = $urandom_range(12, 1);
      for (int i = 0; i < k; i++) begin
        stimA[i] = {randBf(t % 4 == 3), randBf(t % 4 == 3)};
        stimB[i] = {randBf(t % 4 == 3), randBf(t % 4 == 3)};
      end
      runDot(k, {1'($urandom), 8'($urandom_range(134, 120)), 23'($urandom)},
             (t % 2) * 40, "R3 R4 random", got);
    end
    finish();
  end
endmodule